// File: doc/BRIEF.md
# NRZ Pre-Emphasis Level Selector

This block turns a serial NRZ transmit stream into a signed output-level code. A level-setting stage downstream reads the code. One step of the code is worth 0.86 dB. An 8-bit gain-set word, written through a one-cycle strobe, sets the base level. The same word carries an enable bit for pre-emphasis. When pre-emphasis is on, the block looks one bit ahead. A bit whose successor has a different value is sent two steps louder than the base level. This sharpens the edge at each data transition, and it may push the level past the largest base setting.

The serial source supplies the bit now being sent, the bit after it, and a strobe at the start of each bit period. The level code changes only on that strobe, so it stays aligned with the bit on the line. An output-active input forces the level to zero while the transmitter is idle. A clear input zeroes the output stage and leaves the gain-set word untouched, so a general reset of the datapath keeps the configured level and emphasis mode. An illegal gain-set word is refused and raises an error flag.

Top module: `nrz_emph_level`

## Requirements
- R1: After reset, level_code is 0, boost_act is 0 and cfg_err is 0. The gain-set word holds base code 3'b011 with pre-emphasis off.
- R2: cfg_data[2:0] selects the base level as (code - 3) steps: 000 gives -3 and 110 gives +3. It takes effect on the first bit_stb after the write.
- R3: When cfg_data[3] was written as 1 and bit_cur differs from bit_nxt at a bit_stb, the next level_code is base + 2 and boost_act is 1.
- R4: When bit_cur equals bit_nxt, or pre-emphasis is off, level_code equals the base level and boost_act is 0.
- R5: With base code 110 and a boost, level_code reaches +5.
- R6: A write whose cfg_data[2:0] is 111 sets cfg_err in the next cycle and leaves the whole stored word (base code and emphasis bit) unchanged.
- R7: A write with any nonzero bit in cfg_data[7:4] sets cfg_err and leaves the stored word unchanged.
- R8: A legal write clears cfg_err.
- R9: level_code and boost_act change only in the cycle after a bit_stb. A gain-set write between strobes does not change them until the next strobe.
- R10: In the cycle after out_en is low, level_code is 0 and boost_act is 0. A strobe while out_en is low loads nothing else.
- R11: soft_clr zeroes level_code and boost_act in the next cycle and does not alter the stored gain-set word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Datapath clear; gain-set word is kept |
| cfg_wr | input | 1 | Gain-set write strobe |
| cfg_data | input | 8 | Gain-set word: [2:0] base code, [3] pre-emphasis enable, [7:4] must be zero |
| bit_stb | input | 1 | One-cycle pulse at the start of each bit period |
| bit_cur | input | 1 | Bit being transmitted in the starting period |
| bit_nxt | input | 1 | Bit that follows it |
| out_en | input | 1 | Transmit output active |
| level_code | output | 4 | Signed level in 0.86 dB steps |
| boost_act | output | 1 | Current bit carries the pre-emphasis boost |
| cfg_err | output | 1 | Last gain-set write was refused |

## Verification
On every cycle, the assertions check the following. The level stays in the range -3 to +5. It holds between strobes. A boost only comes with a data transition and never when the bits are equal. An idle output or a clear gives zero. An illegal write always raises the error flag. Only the bench's scenarios can show the exact mapping from each base code to its level. The same holds for keeping the stored word, including its emphasis bit, across refused writes and clears, and for a write made mid-bit staying invisible until the next strobe.

// File: rtl/nrz_emph_pkg.sv
package nrz_emph_pkg;
   localparam int CFG_W        = 8;
   localparam int CODE_W       = 3;
   localparam int EMPH_BIT     = 3;
   localparam int BASE_OFFSET  = 3;
   localparam logic [CODE_W-1:0] CODE_BAD   = 3'b111;
   localparam logic [CODE_W-1:0] CODE_RESET = 3'b011;

   typedef struct packed {
      logic              emph;
      logic [CODE_W-1:0] code;
   } gain_cfg_t;

   function automatic logic cfg_legal(input logic [CFG_W-1:0] d);
      return (d[CFG_W-1:EMPH_BIT+1] == '0) && (d[CODE_W-1:0] != CODE_BAD);
   endfunction
endpackage

// File: rtl/emph_gain_reg.sv
module emph_gain_reg
   import nrz_emph_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output gain_cfg_t        cfg,
   output logic             err
);
   gain_cfg_t cfg_q;
   logic      err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{emph: 1'b0, code: CODE_RESET};
         err_q <= 1'b0;
      end else if (wr) begin
         if (cfg_legal(wdata)) begin
            cfg_q <= '{emph: wdata[EMPH_BIT], code: wdata[CODE_W-1:0]};
            err_q <= 1'b0;
         end else begin
            err_q <= 1'b1;
         end
      end
   end

   assign cfg = cfg_q;
   assign err = err_q;
endmodule

// File: rtl/emph_level_calc.sv
module emph_level_calc
   import nrz_emph_pkg::*;
#(
   parameter int LVL_W       = 4,
   parameter int BOOST_STEPS = 2,
   parameter bit EMPH_IMPL   = 1'b1
) (
   input  gain_cfg_t                cfg,
   input  logic                     bit_cur,
   input  logic                     bit_nxt,
   output logic signed [LVL_W-1:0]  level,
   output logic                     boost
);
   localparam int PAD_W = LVL_W - CODE_W;

   logic signed [LVL_W-1:0] base_lvl;

   assign base_lvl = $signed({{PAD_W{1'b0}}, cfg.code}) - LVL_W'(BASE_OFFSET);

   generate
      if (EMPH_IMPL) begin : g_emph
         assign boost = cfg.emph && (bit_cur != bit_nxt);
         assign level = boost ? base_lvl + LVL_W'(BOOST_STEPS) : base_lvl;
      end else begin : g_flat
         logic unused_in;
         assign unused_in = cfg.emph ^ bit_cur ^ bit_nxt;
         assign boost = 1'b0;
         assign level = base_lvl;
      end
   endgenerate
endmodule

// File: rtl/emph_out_stage.sv
module emph_out_stage #(
   parameter int LVL_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_clr,
   input  logic                     out_en,
   input  logic                     bit_stb,
   input  logic signed [LVL_W-1:0]  level_in,
   input  logic                     boost_in,
   output logic signed [LVL_W-1:0]  level_q,
   output logic                     boost_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         boost_q <= 1'b0;
      end else if (soft_clr || !out_en) begin
         level_q <= '0;
         boost_q <= 1'b0;
      end else if (bit_stb) begin
         level_q <= level_in;
         boost_q <= boost_in;
      end
   end
endmodule

// File: rtl/nrz_emph_level.sv
module nrz_emph_level
   import nrz_emph_pkg::*;
#(
   parameter int LVL_W       = 4,
   parameter int BOOST_STEPS = 2,
   parameter bit EMPH_IMPL   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_clr,
   input  logic                     cfg_wr,
   input  logic [CFG_W-1:0]         cfg_data,
   input  logic                     bit_stb,
   input  logic                     bit_cur,
   input  logic                     bit_nxt,
   input  logic                     out_en,
   output logic signed [LVL_W-1:0]  level_code,
   output logic                     boost_act,
   output logic                     cfg_err
);
   localparam int MAX_LVL = (2**CODE_W - 2) - BASE_OFFSET + BOOST_STEPS;
   localparam int LVL_LIM = 2**(LVL_W-1) - 1;

   generate
      if (LVL_W <= CODE_W) begin : g_chk_w
         $error("LVL_W must exceed the base code width");
      end
      if (MAX_LVL > LVL_LIM) begin : g_chk_rng
         $error("LVL_W too narrow for boosted maximum level");
      end
      if (BOOST_STEPS < 1) begin : g_chk_bst
         $error("BOOST_STEPS must be positive");
      end
   endgenerate

   gain_cfg_t               cfg;
   logic signed [LVL_W-1:0] lvl_next;
   logic                    boost_next;

   emph_gain_reg i_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_data),
      .cfg   (cfg),
      .err   (cfg_err)
   );

   emph_level_calc #(
      .LVL_W       (LVL_W),
      .BOOST_STEPS (BOOST_STEPS),
      .EMPH_IMPL   (EMPH_IMPL)
   ) i_calc (
      .cfg     (cfg),
      .bit_cur (bit_cur),
      .bit_nxt (bit_nxt),
      .level   (lvl_next),
      .boost   (boost_next)
   );

   emph_out_stage #(.LVL_W(LVL_W)) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .out_en   (out_en),
      .bit_stb  (bit_stb),
      .level_in (lvl_next),
      .boost_in (boost_next),
      .level_q  (level_code),
      .boost_q  (boost_act)
   );
endmodule

// File: rtl/nrz_emph_level_chk.sv
module nrz_emph_level_chk #(
   parameter int LVL_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     soft_clr,
   input logic                     cfg_wr,
   input logic [7:0]               cfg_data,
   input logic                     bit_stb,
   input logic                     bit_cur,
   input logic                     bit_nxt,
   input logic                     out_en,
   input logic signed [LVL_W-1:0]  level_code,
   input logic                     boost_act,
   input logic                     cfg_err
);
   a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      (level_code >= -3) && (level_code <= 5));

   a_r9_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && out_en && !soft_clr) |=> ($stable(level_code) && $stable(boost_act)));

   a_r4_no_boost_equal_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && (bit_cur == bit_nxt)) |=> !boost_act);

   a_r3_boost_floor: assert property (@(posedge clk) disable iff (!rst_n)
      boost_act |-> (level_code >= -1));

   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> ((level_code == 0) && !boost_act));

   a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> ((level_code == 0) && !boost_act));

   a_r7_high_bits_error: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_data[7:4] != 4'h0)) |=> cfg_err);

   a_r6_bad_code_error: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_data[2:0] == 3'b111)) |=> cfg_err);
endmodule

bind nrz_emph_level nrz_emph_level_chk #(.LVL_W(LVL_W)) i_chk (.*);

// File: tb/test_nrz_emph_level.sv
`timescale 1ns/1ps
module test_nrz_emph_level;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_clr = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [7:0]        cfg_data = 8'h00;
   logic              bit_stb = 1'b0;
   logic              bit_cur = 1'b0;
   logic              bit_nxt = 1'b0;
   logic              out_en = 1'b0;
   logic signed [3:0] level_code;
   logic              boost_act;
   logic              cfg_err;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   nrz_emph_level i_nrz_emph_level (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_wr(cfg_wr),
      .cfg_data(cfg_data), .bit_stb(bit_stb), .bit_cur(bit_cur),
      .bit_nxt(bit_nxt), .out_en(out_en), .level_code(level_code),
      .boost_act(boost_act), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input int lvl, input int bst);
      check({req, " level"}, int'(level_code), lvl);
      check({req, " boost"}, int'(boost_act), bst);
   endtask

   task automatic write_cfg(input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_data = 8'h00;
   endtask

   task automatic strobe(input logic c, input logic n);
      @(negedge clk);
      bit_stb = 1'b1; bit_cur = c; bit_nxt = n;
      @(negedge clk);
      bit_stb = 1'b0;
   endtask

   task automatic t_reset;
      chk_out("R1", 0, 0);
      check("R1 err", int'(cfg_err), 0);
      strobe(1'b0, 1'b0);
      chk_out("R1 default code", 0, 0);
   endtask

   task automatic t_base_levels;
      for (int c = 0; c < 7; c++) begin
         write_cfg(8'(c));
         strobe(1'b1, 1'b1);
         chk_out("R2", c - 3, 0);
      end
   endtask

   task automatic t_boost;
      write_cfg(8'h08);
      strobe(1'b0, 1'b1);
      chk_out("R3 rise", -1, 1);
      strobe(1'b1, 1'b0);
      chk_out("R3 fall", -1, 1);
   endtask

   task automatic t_no_boost;
      write_cfg(8'h08);
      strobe(1'b1, 1'b1);
      chk_out("R4 equal", -3, 0);
      write_cfg(8'h03);
      strobe(1'b0, 1'b1);
      chk_out("R4 off", 0, 0);
   endtask

   task automatic t_max;
      write_cfg(8'h0E);
      strobe(1'b1, 1'b0);
      chk_out("R5", 5, 1);
   endtask

   task automatic t_bad_words;
      write_cfg(8'h0C);
      write_cfg(8'h07);
      check("R6 err", int'(cfg_err), 1);
      strobe(1'b0, 1'b1);
      chk_out("R6 kept", 3, 1);
      write_cfg(8'h13);
      check("R7 err", int'(cfg_err), 1);
      strobe(1'b1, 1'b0);
      chk_out("R7 kept", 3, 1);
      write_cfg(8'h03);
      check("R8 err clr", int'(cfg_err), 0);
   endtask

   task automatic t_strobe_only;
      write_cfg(8'h03);
      strobe(1'b0, 1'b0);
      write_cfg(8'h06);
      repeat (3) @(negedge clk);
      chk_out("R9 hold", 0, 0);
      strobe(1'b0, 1'b0);
      chk_out("R9 apply", 3, 0);
   endtask

   task automatic t_out_en;
      write_cfg(8'h0E);
      strobe(1'b0, 1'b1);
      chk_out("R10 pre", 5, 1);
      @(negedge clk); out_en = 1'b0;
      @(negedge clk);
      chk_out("R10 idle", 0, 0);
      strobe(1'b1, 1'b0);
      chk_out("R10 strobe idle", 0, 0);
      out_en = 1'b1;
      @(negedge clk);
      chk_out("R10 resume hold", 0, 0);
   endtask

   task automatic t_soft_clr;
      write_cfg(8'h0E);
      strobe(1'b0, 1'b1);
      @(negedge clk); soft_clr = 1'b1;
      @(negedge clk); soft_clr = 1'b0;
      chk_out("R11 clr", 0, 0);
      strobe(1'b1, 1'b0);
      chk_out("R11 kept", 5, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      out_en = 1'b1;
      @(negedge clk);
      t_reset();
      t_base_levels();
      t_boost();
      t_no_boost();
      t_max();
      t_bad_words();
      t_strobe_only();
      t_out_en();
      t_soft_clr();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule